// File: doc/BRIEF.md
# EDO DRAM Access Controller with Refresh Scheduling

This block sits between a synchronous host and a 4M x 16 extended-data-out DRAM. The DRAM has 4096 rows of 1024 sixteen-bit words. A host hands over one word access at a time through a valid/ready request channel. Each request carries a 22-bit word address, a write flag, 16 bits of write data and two byte enables. The controller plays out the strobe sequence for that access on the memory pins. It places the row on the shared address pins and lowers the row strobe. It then places the column and lowers the column strobe of each enabled byte lane. Finally it lets the row strobe recover. All strobes are active low. Timing gaps are whole clock cycles set by parameters.

The host applies back-pressure only on the request side. A request moves when `req_valid` and `req_ready` are both high at a rising clock edge. The host must hold every request field stable until that edge. The controller samples all fields at that edge, and later changes to them have no effect. The controller drops `req_ready` for the whole of an access and for as long as a refresh is owed. Read data comes back as a single-cycle `rd_valid` pulse with no back-pressure, so the host must take it in that cycle.

A free-running timer requests one CAS-before-RAS refresh cycle per `CLK_KHZ*REF_MS/REF_ROWS` clocks. With the default parameters this gives 4096 refreshes per 64 ms. A refresh that is owed wins over a new request. It never cuts into an access that has already started. The data bus is split into an output, an output enable and an input, and the pad ring merges them into the bidirectional pins.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset, and whenever idle, `dram_ras_n`, `dram_casl_n`, `dram_cash_n`, `dram_we_n` and `dram_oe_n` are all 1. In that state `dram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1 unless a refresh is owed.
- R2: When `dram_ras_n` falls for an access, `dram_addr` holds the row, which is `req_addr[21:10]`. When the column strobes fall, `dram_addr` holds the column: `req_addr[9:0]` in bits [9:0], with bits [11:10] at 0.
- R3: During an access, `req_be[0]` decides whether `dram_casl_n` goes low (lower byte, data bits [7:0]). `req_be[1]` decides the same for `dram_cash_n` (upper byte, data bits [15:8]). A lane whose enable is 0 keeps its strobe at 1 for the whole access.
- R4: For a write, `dram_we_n` is 0 from the row strobe falling through the whole column phase, so it is already low before any column strobe falls. `dram_oe_n` stays 1, and `dram_dq_oe` is 1 while `dram_we_n` is 0, with `dram_dq_o` equal to the write data. For a read, `dram_we_n` stays 1, `dram_oe_n` is 0 during the column phase and `dram_dq_oe` stays 0. `dram_we_n` and `dram_oe_n` are never both 0.
- R5: A read captures `dram_dq_i` in the last column cycle. `rd_valid` is high for exactly one cycle. That cycle starts T_RCD+T_CAS rising edges after the accepting edge, and `rd_data` carries the captured word during it.
- R6: During an access, the row strobe is low for exactly T_RCD cycles before the column strobes fall. The column strobes stay low for exactly T_CAS cycles. Between any two low periods, `dram_ras_n` stays high for at least T_RP cycles.
- R7: Refresh cycles start once per `CLK_KHZ*REF_MS/REF_ROWS` cycles. In each one, both column strobes are low before `dram_ras_n` falls and `dram_we_n` stays 1. No refresh request is lost.
- R8: While a refresh is owed, `req_ready` is 0, so the refresh keeps its rate under back-to-back requests. `dram_ras_n` never rises during an access before its column strobe has pulsed.
- R9: A request is taken only when `req_valid` and `req_ready` are both high. Each taken request produces exactly one access. `req_ready` is 0 while the row strobe is low, and changes to the request fields after acceptance have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in [21:10], column in [9:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | One-cycle read data pulse |
| rd_data | output | 16 | Read data |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower byte column strobe, active low |
| dram_cash_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | 16 | Data returned by the memory |

## Verification
Every strobe, the address pins and the bus enable change at the rising edge that accepts a request. The row phase then lasts T_RCD cycles and the column phase T_CAS cycles. `rd_valid` rises T_RCD+T_CAS edges after acceptance, and the row strobe stays high for at least T_RP cycles afterwards. The bench samples at falling edges and counts those edges from the accepting edge to the read pulse. It also measures the row and column phase lengths from the pins cycle by cycle. Refresh is judged over a window of ten refresh periods, with a tolerance of one cycle at each end of the window.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ROW  = 3'd1,
    S_COL  = 3'd2,
    S_PRE  = 3'd3,
    S_RFC  = 3'd4,
    S_RFR  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } ctl_pins_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels that belong to a sequencer state for a given direction.
  function automatic ctl_pins_t decode_ctl(input seq_state_e st, input logic wr);
    ctl_pins_t p;
    logic row_open;
    row_open = (st == S_ROW) || (st == S_COL);
    p.ras_n  = !(row_open || (st == S_RFR));
    p.we_n   = !(wr && row_open);
    p.oe_n   = !(!wr && (st == S_COL));
    p.dq_oe  = wr && row_open;
    return p;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int PERIOD = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          tick;

  assign tick = (cnt_q == '0);
  assign pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(PERIOD - 1);
      pend_q <= 1'b0;
    end else begin
      cnt_q <= tick ? CW'(PERIOD - 1) : cnt_q - CW'(1);
      if (tick)     pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
    end
  end

  // R7: a new period never arrives while the previous refresh is still owed
  assert_no_lost_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (!pend_q || ack));

endmodule

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int PIN_W = 12
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  output logic [PIN_W-1:0]       row_pins,
  output logic [PIN_W-1:0]       col_pins
);
  assign row_pins = PIN_W'(addr[ROW_W+COL_W-1:COL_W]);
  assign col_pins = PIN_W'(addr[COL_W-1:0]);
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int PIN_W  = 12,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3,
  parameter int T_CSR  = 1,
  parameter int T_RAS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PIN_W-1:0]  req_row,
  input  logic [PIN_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_pend,
  output logic              ref_ack,
  output logic [PIN_W-1:0]  mem_addr,
  output logic              ras_n,
  output logic [LANES-1:0]  cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int T_MAX = imax(imax(imax(T_RCD, T_CAS), imax(T_RP, T_CSR)), T_RAS);
  localparam int CNT_W = $clog2(T_MAX) + 1;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [LANES-1:0]  be_q, be_d;
  logic [PIN_W-1:0]  row_q, row_d, col_q, col_d;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              rdv_q;
  logic              accept, last, capture;
  logic [LANES-1:0]  cas_d, cas_q;
  logic              ras_q, we_q, oe_q, dqoe_q;
  logic [PIN_W-1:0]  addr_q;

  assign last      = (cnt_q == '0);
  assign req_ready = (state_q == S_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign ref_ack   = (state_q == S_IDLE) && ref_pend;
  assign capture   = (state_q == S_COL) && last && !wr_q;

  // Sequencer: each phase loads its length minus one and leaves at zero.
  always_comb begin
    state_d = state_q;
    cnt_d   = last ? cnt_q : cnt_q - CNT_W'(1);
    case (state_q)
      S_IDLE: begin
        if (ref_pend) begin
          state_d = S_RFC;
          cnt_d   = CNT_W'(T_CSR - 1);
        end else if (req_valid) begin
          state_d = S_ROW;
          cnt_d   = CNT_W'(T_RCD - 1);
        end
      end
      S_ROW: if (last) begin state_d = S_COL; cnt_d = CNT_W'(T_CAS - 1); end
      S_COL: if (last) begin state_d = S_PRE; cnt_d = CNT_W'(T_RP - 1);  end
      S_RFC: if (last) begin state_d = S_RFR; cnt_d = CNT_W'(T_RAS - 1); end
      S_RFR: if (last) begin state_d = S_PRE; cnt_d = CNT_W'(T_RP - 1);  end
      S_PRE: if (last) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign wr_d  = accept ? req_write : wr_q;
  assign be_d  = accept ? req_be    : be_q;
  assign row_d = accept ? req_row   : row_q;
  assign col_d = accept ? req_col   : col_q;

  // Per-lane column strobe: enabled lanes in the column phase, all lanes in refresh.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cas_d[l] = !(((state_d == S_COL) && be_d[l]) ||
                        (state_d == S_RFC) || (state_d == S_RFR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      rdv_q   <= 1'b0;
      cas_q   <= '1;
      ras_q   <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      dqoe_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      be_q    <= be_d;
      row_q   <= row_d;
      col_q   <= col_d;
      if (accept) wd_q <= req_wdata;
      if (capture) rd_q <= dq_i;
      rdv_q   <= capture;
      cas_q   <= cas_d;
      {ras_q, we_q, oe_q, dqoe_q} <= decode_ctl(state_d, wr_d);
      addr_q  <= (state_d == S_ROW) ? row_d : col_d;
    end
  end

  assign mem_addr = addr_q;
  assign ras_n    = ras_q;
  assign cas_n    = cas_q;
  assign we_n     = we_q;
  assign oe_n     = oe_q;
  assign dq_o     = wd_q;
  assign dq_oe    = dqoe_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rd_q;

  // R4: a write column strobe only falls after write enable was already low
  assert_we_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(&cas_q) && !(&cas_q) && !we_q) |-> $past(!we_q));

  // R7: a refresh row strobe falls only with every column strobe already low
  assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_q) && !(&cas_q)) |-> $past(cas_q == '0));

  // R6: the row strobe recovers for at least one cycle after each low period
  assert_ras_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_q) |=> ras_q);

  // R5: read data valid is a single-cycle pulse
  assert_read_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |=> !rdv_q);

  // R9: an accepted request opens its row at the accepting edge
  assert_accept_opens_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ras_q);

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int CLK_KHZ  = 100000,
  parameter int REF_MS   = 64,
  parameter int REF_ROWS = 4096,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 10,
  parameter int T_RCD    = 2,
  parameter int T_CAS    = 2,
  parameter int T_RP     = 3,
  parameter int T_CSR    = 1,
  parameter int T_RAS    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ROW_W+COL_W-1:0]        req_addr,
  input  logic [15:0]                   req_wdata,
  input  logic [1:0]                    req_be,
  output logic                          rd_valid,
  output logic [15:0]                   rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                          dram_ras_n,
  output logic                          dram_casl_n,
  output logic                          dram_cash_n,
  output logic                          dram_we_n,
  output logic                          dram_oe_n,
  output logic [15:0]                   dram_dq_o,
  output logic                          dram_dq_oe,
  input  logic [15:0]                   dram_dq_i
);
  localparam int DATA_W     = 16;
  localparam int LANES      = DATA_W / 8;
  localparam int PIN_W      = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int REF_PERIOD = (CLK_KHZ * REF_MS) / REF_ROWS;

  logic [PIN_W-1:0] row_pins, col_pins;
  logic [LANES-1:0] cas_n;
  logic             ref_pend, ref_ack;

  edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_split (
    .addr     (req_addr),
    .row_pins (row_pins),
    .col_pins (col_pins)
  );

  edo_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (ref_ack),
    .pend  (ref_pend)
  );

  edo_seq #(
    .DATA_W(DATA_W), .LANES(LANES), .PIN_W(PIN_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS(T_RAS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_row   (row_pins),
    .req_col   (col_pins),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .mem_addr  (dram_addr),
    .ras_n     (dram_ras_n),
    .cas_n     (cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .dq_o      (dram_dq_o),
    .dq_oe     (dram_dq_oe),
    .dq_i      (dram_dq_i)
  );

  assign dram_casl_n = cas_n[0];
  assign dram_cash_n = cas_n[LANES-1];

endmodule

// File: tb/sim_edo_dram_ctrl.sv
module sim_edo_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ   = 4096;
  localparam int RCD   = 2;
  localparam int CAS   = 2;
  localparam int RP    = 2;
  localparam int CSR   = 1;
  localparam int RASW  = 3;
  localparam int REF_P = (KHZ * 64) / 4096;

  // {write, be[1:0], addr[21:0], wdata[15:0]}
  localparam logic [40:0] VEC [8] = '{
    {1'b1, 2'b11, 22'h000000, 16'h1234},
    {1'b0, 2'b11, 22'h000000, 16'h0000},
    {1'b1, 2'b01, 22'h3FFFFF, 16'hABCD},
    {1'b1, 2'b10, 22'h2AA155, 16'h5AA5},
    {1'b0, 2'b11, 22'h3FFFFF, 16'h0000},
    {1'b0, 2'b01, 22'h012345, 16'h0000},
    {1'b1, 2'b11, 22'h000400, 16'hFFFF},
    {1'b0, 2'b10, 22'h3FF3FF, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic rd_valid;
  logic [15:0] rd_data;
  logic [11:0] dram_addr;
  logic dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_o, dram_dq_i;

  int checks = 0, errors = 0, cyc = 0;
  logic done = 1'b0;

  // pin monitor state
  logic prev_ras = 1'b1, prev_casa = 1'b0, casa, in_acc = 1'b0, seen_cas = 1'b0, have_pre = 1'b0;
  logic [11:0] m_row = '0, m_col = '0;
  logic [1:0]  m_lanes = '0;
  logic m_we = 1'b1, m_oe = 1'b1, m_dqoe = 1'b0;
  logic [15:0] m_dq = '0;
  int rcd = 0, m_rcd = 0, casw = 0, m_casw = 0, pre = 0, min_pre = 1000;
  int cbr_cnt = 0, cbr_bad = 0, acc_cnt = 0, acc_ras = 0, ready_bad = 0, interrupted = 0, fight = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mdl(input logic [11:0] r, input logic [9:0] c);
    return {r[11:4], c[7:0]} ^ {c[9:8], r[3:0], 10'h2B5};
  endfunction

  assign dram_dq_i = dram_oe_n ? 16'h0000 : mdl(m_row, dram_addr[9:0]);

  edo_dram_ctrl #(
    .CLK_KHZ(KHZ), .T_RCD(RCD), .T_CAS(CAS), .T_RP(RP), .T_CSR(CSR), .T_RAS(RASW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o),
    .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // Monitor: samples mid-cycle at falling edges, one sample per clock cycle.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<60000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      casa = !dram_casl_n || !dram_cash_n;
      if (req_valid && req_ready) acc_cnt++;
      if (!dram_we_n && !dram_oe_n) fight++;
      if (prev_ras && !dram_ras_n) begin
        if (have_pre && pre < min_pre) min_pre = pre;
        if (casa) begin
          cbr_cnt++;
          if (!prev_casa || dram_casl_n || dram_cash_n || !dram_we_n) cbr_bad++;
        end else begin
          in_acc = 1'b1; seen_cas = 1'b0; acc_ras++; m_row = dram_addr; rcd = 1;
        end
      end else if (!dram_ras_n && in_acc && !casa && !seen_cas) begin
        rcd++;
      end
      if (in_acc && casa && !prev_casa) begin
        m_rcd = rcd; m_col = dram_addr; m_lanes = {!dram_cash_n, !dram_casl_n};
        m_we = dram_we_n; m_oe = dram_oe_n; m_dqoe = dram_dq_oe; m_dq = dram_dq_o;
        casw = 1; seen_cas = 1'b1;
      end else if (in_acc && casa) begin
        casw++;
      end
      if (in_acc && !casa && prev_casa) m_casw = casw;
      if (in_acc && !dram_ras_n && req_ready) ready_bad++;
      if (!prev_ras && dram_ras_n) begin
        if (in_acc && !seen_cas) interrupted++;
        in_acc = 1'b0; pre = 1; have_pre = 1'b1;
      end else if (dram_ras_n) begin
        pre++;
      end
      prev_ras = dram_ras_n;
      prev_casa = casa;
    end
  end

  task automatic do_access(input logic wr, input logic [1:0] be, input logic [21:0] a,
                           input logic [15:0] wd, input int gap,
                           output int lat, output logic [15:0] rdat, output logic pulse_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; req_be = ~be; req_addr = ~a; req_wdata = ~wd;
    lat = 0; rdat = '0; pulse_ok = 1'b1;
    if (!wr) begin
      while (!rd_valid && lat < 40) begin
        @(posedge clk); lat++; @(negedge clk);
      end
      rdat = rd_data;
      @(negedge clk);
      pulse_ok = !rd_valid;
    end
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    int lat, c0, t0;
    logic [15:0] rdat;
    logic pok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset and idle levels
    chk("R1 ras_n", dram_ras_n, 1);
    chk("R1 casl_n", dram_casl_n, 1);
    chk("R1 cash_n", dram_cash_n, 1);
    chk("R1 we_n", dram_we_n, 1);
    chk("R1 oe_n", dram_oe_n, 1);
    chk("R1 dq_oe", dram_dq_oe, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 req_ready", req_ready, 1);

    // Vector table walk
    for (int i = 0; i < 8; i++) begin
      logic wr;
      logic [1:0] be;
      logic [21:0] a;
      logic [15:0] wd;
      {wr, be, a, wd} = VEC[i];
      do_access(wr, be, a, wd, RCD + CAS + RP + 2, lat, rdat, pok);
      chk("R2 row", m_row, a[21:10]);
      chk("R2 column", m_col, {2'b00, a[9:0]});
      chk("R3 lanes", m_lanes, be);
      chk("R6 ras-to-cas", m_rcd, RCD);
      chk("R6 cas width", m_casw, CAS);
      if (wr) begin
        chk("R4 write we_n", m_we, 0);
        chk("R4 write oe_n", m_oe, 1);
        chk("R4 write dq_oe", m_dqoe, 1);
        chk("R9 write data held", m_dq, wd);
      end else begin
        chk("R4 read we_n", m_we, 1);
        chk("R4 read oe_n", m_oe, 0);
        chk("R4 read dq_oe", m_dqoe, 0);
        chk("R5 read latency", lat, RCD + CAS);
        chk("R5 read data", rdat, mdl(a[21:10], a[9:0]));
        chk("R5 single pulse", pok, 1);
      end
    end

    // R7 refresh rate while idle
    c0 = cbr_cnt;
    repeat (REF_P * 10) @(negedge clk);
    chk_rng("R7 idle refresh count", cbr_cnt - c0, 9, 11);
    chk("R7 refresh shape", cbr_bad, 0);

    // R8 refresh keeps its rate under back-to-back requests
    c0 = cbr_cnt;
    t0 = cyc;
    while (cyc - t0 < REF_P * 10) begin
      do_access(1'b0, 2'b11, 22'(cyc * 37), 16'h0, 0, lat, rdat, pok);
    end
    chk_rng("R8 loaded refresh count", cbr_cnt - c0, 9, 11);
    chk("R8 no interrupted access", interrupted, 0);
    chk("R7 refresh shape under load", cbr_bad, 0);

    repeat (RCD + CAS + RP + 4) @(negedge clk);
    chk("R9 one access per accept", acc_ras, acc_cnt);
    chk("R9 ready low in access", ready_bad, 0);
    chk_rng("R6 precharge min", min_pre, RP, 1000);
    chk("R4 no we/oe overlap", fight, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule